// File: doc/BRIEF.md
# Relative Branch Condition Unit

This unit decides whether a relative branch is taken and works out where it lands. On a cycle with `in_valid` high it takes a 4-bit condition code, a flag that says an alternate-page prefix came before the opcode, the six condition flags (overflow, interrupt mask, half-carry, negative, zero, carry), the level of the external interrupt line, the address of the next instruction and a signed 8-bit displacement. The same unit also decides bit-test branches. In that case the condition code holds a bit index in bits 3:1 and a sense bit in bit 0, and the tested memory byte arrives on `test_byte`.

The result is registered. One clock after an accepted request, `out_valid` is high for one cycle, and `taken`, `illegal` and `target` hold the decision. These three outputs keep their values until the next request. Instruction fetch and flag generation belong to the surrounding pipeline.

Control is a two-state machine. In `ST_IDLE` no result is being shown. In `ST_RESULT` a result is being shown. The transition `ACCEPT` (`in_valid` high) leads from either state to `ST_RESULT`. The transition `DRAIN` (`in_valid` low) leads from either state to `ST_IDLE`. Reset enters `ST_IDLE`.

Top module: `brc_branch_unit`

## Requirements
- R1: After reset, `out_valid`, `taken` and `illegal` are 0 and `target` is 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high, and 0 otherwise. `taken`, `illegal` and `target` are updated in that same cycle.
- R3: With no prefix and `bit_test` low, codes 0x0 to 0xB are decided as follows. 0 is always taken and 1 is never taken. 2 is taken when C=0 and Z=0, and 3 when C=1 or Z=1. 4 is taken when C=0 and 5 when C=1. 6 is taken when Z=0 and 7 when Z=1. 8 is taken when V=0 and 9 when V=1. A is taken when N=0 and B when N=1.
- R4: With no prefix, code 0xC is taken when Z=0 and N=V, and code 0xD when Z=1 or N≠V. Code 0xE is taken when N=V, and code 0xF when N≠V.
- R5: With the prefix, code 0x8 is taken when H=0 and code 0x9 when H=1.
- R6: With the prefix, code 0xC is taken when I=0 and 0xD when I=1. Code 0xE is taken when the interrupt line is low, and 0xF when it is high.
- R7: With the prefix, codes 0x0 to 0x7, 0xA and 0xB are decided exactly as without it.
- R8: With `bit_test` high and no prefix, `cond_code[3:1]` selects bit k of `test_byte`. If `cond_code[0]`=0 the branch is taken when bit k is 1. If `cond_code[0]`=1 the branch is taken when bit k is 0.
- R9: A bit test with the prefix is undefined. It sets `illegal` to 1 and `taken` to 0. Every other combination sets `illegal` to 0.
- R10: `target[15:0]` is `next_addr[15:0]` plus the sign-extended offset, modulo 2^16. `target[23:16]` equals `next_addr[23:16]`.
- R11: In cycles after a cycle with `in_valid` low, `taken`, `illegal` and `target` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| bit_test | input | 1 | 1 = bit-test branch, 0 = flag branch |
| cond_code | input | 4 | Condition code, or bit index and sense |
| alt_prefix | input | 1 | Alternate-page prefix present |
| flag_v | input | 1 | Overflow flag |
| flag_i | input | 1 | Interrupt mask flag |
| flag_h | input | 1 | Half-carry flag |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| irq_level | input | 1 | External interrupt line level |
| next_addr | input | 24 | Address of the next instruction |
| rel_offset | input | 8 | Signed displacement |
| test_byte | input | 8 | Memory byte for bit tests |
| out_valid | output | 1 | Result strobe |
| taken | output | 1 | Branch taken |
| illegal | output | 1 | Undefined request |
| target | output | 24 | Branch destination |

## Verification
Every result is due exactly one clock after the edge that captures the request. The bench drives inputs on the falling edge, drops `in_valid` at the next falling edge and samples all outputs there, half a period after the capturing edge. One falling edge later, with `in_valid` low and the other inputs scrambled, it checks that `out_valid` has fallen and that the decision and address have not moved. The sweeps cover every code with both prefix states, all 64 flag patterns and both line levels. They also cover every bit-test code against all 256 bytes, and all 256 offsets against addresses placed at the 16-bit wrap boundaries.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } brc_state_e;

    typedef struct packed {
        logic v;
        logic i;
        logic h;
        logic n;
        logic z;
        logic c;
    } brc_flags_t;

    localparam logic [3:0] CC_ALWAYS = 4'h0;
    localparam logic [3:0] CC_NEVER  = 4'h1;
    localparam logic [3:0] CC_UGT    = 4'h2;
    localparam logic [3:0] CC_ULE    = 4'h3;
    localparam logic [3:0] CC_NC     = 4'h4;
    localparam logic [3:0] CC_C      = 4'h5;
    localparam logic [3:0] CC_NE     = 4'h6;
    localparam logic [3:0] CC_EQ     = 4'h7;
    localparam logic [3:0] CC_NV     = 4'h8;
    localparam logic [3:0] CC_V      = 4'h9;
    localparam logic [3:0] CC_PL     = 4'hA;
    localparam logic [3:0] CC_MI     = 4'hB;
    localparam logic [3:0] CC_SGT    = 4'hC;
    localparam logic [3:0] CC_SLE    = 4'hD;
    localparam logic [3:0] CC_SGE    = 4'hE;
    localparam logic [3:0] CC_SLT    = 4'hF;

endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
(
    input  logic [3:0]  code,
    input  logic        alt,
    input  brc_flags_t  flg,
    input  logic        line_lvl,
    output logic        hit
);

    logic signed_eq;

    always_comb begin
        signed_eq = (flg.n == flg.v);
        hit = 1'b0;
        unique case (code)
            CC_ALWAYS: hit = 1'b1;
            CC_NEVER:  hit = 1'b0;
            CC_UGT:    hit = ~flg.c & ~flg.z;
            CC_ULE:    hit = flg.c | flg.z;
            CC_NC:     hit = ~flg.c;
            CC_C:      hit = flg.c;
            CC_NE:     hit = ~flg.z;
            CC_EQ:     hit = flg.z;
            CC_NV:     hit = alt ? ~flg.h : ~flg.v;
            CC_V:      hit = alt ?  flg.h :  flg.v;
            CC_PL:     hit = ~flg.n;
            CC_MI:     hit = flg.n;
            CC_SGT:    hit = alt ? ~flg.i : (~flg.z & signed_eq);
            CC_SLE:    hit = alt ?  flg.i : (flg.z | ~signed_eq);
            CC_SGE:    hit = alt ? ~line_lvl : signed_eq;
            CC_SLT:    hit = alt ?  line_lvl : ~signed_eq;
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/brc_bit_probe.sv
module brc_bit_probe #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [IDX_W-1:0]  idx,
    input  logic              want_clear,
    output logic              hit
);

    logic sel_bit;

    always_comb begin
        sel_bit = data[idx];
        hit     = want_clear ? ~sel_bit : sel_bit;
    end

endmodule

// File: rtl/brc_target_calc.sv
module brc_target_calc #(
    parameter int ADDR_W = 24,
    parameter int WRAP_W = 16,
    parameter int OFS_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] dest
);

    logic [WRAP_W-1:0] ofs_ext;
    logic [WRAP_W-1:0] low_sum;

    always_comb begin
        ofs_ext = {{(WRAP_W-OFS_W){ofs[OFS_W-1]}}, ofs};
        low_sum = base[WRAP_W-1:0] + ofs_ext;
    end

    generate
        if (WRAP_W < ADDR_W) begin : g_keep_upper
            assign dest = {base[ADDR_W-1:WRAP_W], low_sum};
        end else begin : g_full_wrap
            assign dest = low_sum;
        end
    endgenerate

endmodule

// File: rtl/brc_branch_unit.sv
module brc_branch_unit
    import brc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WRAP_W = 16,
    parameter int OFS_W  = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W),
    localparam int CODE_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              bit_test,
    input  logic [CODE_W-1:0] cond_code,
    input  logic              alt_prefix,
    input  logic              flag_v,
    input  logic              flag_i,
    input  logic              flag_h,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              irq_level,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [OFS_W-1:0]  rel_offset,
    input  logic [DATA_W-1:0] test_byte,
    output logic              out_valid,
    output logic              taken,
    output logic              illegal,
    output logic [ADDR_W-1:0] target
);

    brc_state_e  state_q, state_d;
    brc_flags_t  flags_in;
    logic        cond_hit;
    logic        bit_hit;
    logic        undef_req;
    logic        decide;
    logic [ADDR_W-1:0] dest_w;

    assign flags_in = '{v: flag_v, i: flag_i, h: flag_h,
                        n: flag_n, z: flag_z, c: flag_c};

    brc_cond_eval u_cond (
        .code     (cond_code),
        .alt      (alt_prefix),
        .flg      (flags_in),
        .line_lvl (irq_level),
        .hit      (cond_hit)
    );

    brc_bit_probe #(.DATA_W(DATA_W)) u_bit (
        .data       (test_byte),
        .idx        (cond_code[CODE_W-1:1]),
        .want_clear (cond_code[0]),
        .hit        (bit_hit)
    );

    brc_target_calc #(.ADDR_W(ADDR_W), .WRAP_W(WRAP_W), .OFS_W(OFS_W)) u_tgt (
        .base (next_addr),
        .ofs  (rel_offset),
        .dest (dest_w)
    );

    always_comb begin
        undef_req = bit_test & alt_prefix;
        if (undef_req)     decide = 1'b0;
        else if (bit_test) decide = bit_hit;
        else               decide = cond_hit;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken   <= 1'b0;
            illegal <= 1'b0;
            target  <= '0;
        end else if (in_valid) begin
            taken   <= decide;
            illegal <= undef_req;
            target  <= dest_w;
        end
    end

    assign out_valid = (state_q == ST_RESULT);

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_ILLEGAL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> !taken); // R9
    AST_ALT_BITTEST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bit_test && alt_prefix) |=> illegal); // R9
    AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bit_test && cond_code == CC_ALWAYS) |=> taken); // R3
    AST_NEVER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bit_test && cond_code == CC_NEVER) |=> !taken); // R3
    AST_BIT_SET_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bit_test && !alt_prefix && !cond_code[0])
        |=> taken == $past(test_byte[cond_code[CODE_W-1:1]])); // R8
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(taken) && $stable(illegal) && $stable(target))); // R11

    generate
        if (WRAP_W < ADDR_W) begin : g_upper_chk
            AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> target[ADDR_W-1:WRAP_W] == $past(next_addr[ADDR_W-1:WRAP_W])); // R10
        end
    endgenerate

endmodule

// File: tb/brc_branch_unit_tb.sv
module brc_branch_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        bit_test = 1'b0;
    logic [3:0]  cond_code = '0;
    logic        alt_prefix = 1'b0;
    logic        flag_v = 0, flag_i = 0, flag_h = 0, flag_n = 0, flag_z = 0, flag_c = 0;
    logic        irq_level = 1'b0;
    logic [23:0] next_addr = '0;
    logic [7:0]  rel_offset = '0;
    logic [7:0]  test_byte = '0;
    logic        out_valid, taken, illegal;
    logic [23:0] target;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brc_branch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bit_test(bit_test),
        .cond_code(cond_code), .alt_prefix(alt_prefix),
        .flag_v(flag_v), .flag_i(flag_i), .flag_h(flag_h),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
        .irq_level(irq_level), .next_addr(next_addr), .rel_offset(rel_offset),
        .test_byte(test_byte), .out_valid(out_valid), .taken(taken),
        .illegal(illegal), .target(target)
    );

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (code=%h alt=%b bt=%b)",
                     tag, act, exp, cond_code, alt_prefix, bit_test);
        end
    endtask

    function automatic logic exp_flag_branch(input logic alt, input logic [3:0] code,
                                             input logic [5:0] f, input logic line);
        logic v, i, h, n, z, c;
        {v, i, h, n, z, c} = f;
        case (code)
            4'h0: return 1'b1;
            4'h1: return 1'b0;
            4'h2: return !c && !z;
            4'h3: return c || z;
            4'h4: return !c;
            4'h5: return c;
            4'h6: return !z;
            4'h7: return z;
            4'h8: return alt ? !h : !v;
            4'h9: return alt ? h : v;
            4'hA: return !n;
            4'hB: return n;
            4'hC: return alt ? !i : (!z && (n == v));
            4'hD: return alt ? i : (z || (n != v));
            4'hE: return alt ? !line : (n == v);
            default: return alt ? line : (n != v);
        endcase
    endfunction

    function automatic logic [23:0] exp_dest(input logic [23:0] a, input logic [7:0] o);
        logic [15:0] lo;
        lo = a[15:0] + {{8{o[7]}}, o};
        return {a[23:16], lo};
    endfunction

    // issue one request, check result one edge later, then check hold
    task automatic run_one(input string tag, input logic exp_taken,
                           input logic exp_illegal, input logic [23:0] exp_tgt);
        logic        held_taken;
        logic [23:0] held_tgt;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 out_valid", {23'd0, out_valid}, 24'd1);
        chk(tag, {23'd0, taken}, {23'd0, exp_taken});
        chk("R9 illegal", {23'd0, illegal}, {23'd0, exp_illegal});
        chk("R10 target", target, exp_tgt);
        held_taken = taken;
        held_tgt   = target;
        cond_code  = ~cond_code;
        alt_prefix = ~alt_prefix;
        bit_test   = ~bit_test;
        test_byte  = ~test_byte;
        next_addr  = next_addr ^ 24'h5A5A5A;
        @(negedge clk);
        chk("R2 quiet", {23'd0, out_valid}, 24'd0);
        chk("R11 hold taken", {23'd0, taken}, {23'd0, held_taken});
        chk("R11 hold target", target, held_tgt);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 out_valid", {23'd0, out_valid}, 24'd0);
        chk("R1 taken", {23'd0, taken}, 24'd0);
        chk("R1 illegal", {23'd0, illegal}, 24'd0);
        chk("R1 target", target, 24'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // flag branches: all codes, prefix states, flags, line levels
        for (int alt = 0; alt < 2; alt++) begin
            for (int code = 0; code < 16; code++) begin
                for (int f = 0; f < 64; f++) begin
                    for (int ln = 0; ln < 2; ln++) begin
                        string tag;
                        logic  e;
                        if (alt == 0) tag = (code < 12) ? "R3" : "R4";
                        else if (code == 8 || code == 9) tag = "R5";
                        else if (code >= 12) tag = "R6";
                        else tag = "R7";
                        bit_test   = 1'b0;
                        alt_prefix = alt[0];
                        cond_code  = code[3:0];
                        {flag_v, flag_i, flag_h, flag_n, flag_z, flag_c} = f[5:0];
                        irq_level  = ln[0];
                        next_addr  = {f[5:0], 2'b00, code[3:0], 12'hFF0};
                        rel_offset = {f[3:0], code[3:0]};
                        e = exp_flag_branch(alt[0], code[3:0], f[5:0], ln[0]);
                        run_one(tag, e, 1'b0, exp_dest(next_addr, rel_offset));
                    end
                end
            end
        end

        // bit-test branches: every code against every byte, both prefix states
        for (int alt = 0; alt < 2; alt++) begin
            for (int code = 0; code < 16; code++) begin
                for (int b = 0; b < 256; b++) begin
                    logic e;
                    logic [7:0] bv;
                    bv = b[7:0];
                    bit_test   = 1'b1;
                    alt_prefix = alt[0];
                    cond_code  = code[3:0];
                    test_byte  = bv;
                    next_addr  = {bv, 16'hFFFF - {8'd0, bv}};
                    rel_offset = bv ^ 8'h80;
                    if (alt != 0) e = 1'b0;
                    else e = code[0] ? !bv[code[3:1]] : bv[code[3:1]];
                    run_one(alt != 0 ? "R9" : "R8", e, alt[0],
                            exp_dest(next_addr, rel_offset));
                end
            end
        end

        // target wrap sweep: every offset at the 16-bit boundaries
        for (int a = 0; a < 4; a++) begin
            for (int o = 0; o < 256; o++) begin
                logic [23:0] base;
                case (a)
                    0: base = 24'h12FFF0;
                    1: base = 24'hAB0005;
                    2: base = 24'h000000;
                    default: base = 24'hFFFFFF;
                endcase
                bit_test   = 1'b0;
                alt_prefix = 1'b0;
                cond_code  = 4'h0;
                next_addr  = base;
                rel_offset = o[7:0];
                run_one("R10", 1'b1, 1'b0, exp_dest(base, o[7:0]));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule